// File: doc/BRIEF.md
# Guarded Operating-Mode Register

This block holds the chip's 3-bit operating mode in the upper three bits of one byte-wide control register. While reset is held, the mode follows three external strap pins. The value present on the last clock edge before reset is released is kept as the starting mode. Lower bits are not implemented.

After reset, software can ask for a move from a single-chip mode to the matching expanded mode by writing the entry code to the register. The first write from any non-special mode is the only one that counts: it either performs the permitted step or is rejected. Either way it closes the register to further writes until the next reset. A write while the device is secured never changes the mode. Special modes are exempt from both the lock and the secure rule.

In emulation modes, reads of the register return a byte supplied by an external bus, and writes are also presented on an outgoing strobe with their data.

Top module: `mode_guard_reg`

## Requirements
- R1: While `rst_n` is low, `mode_o` equals `mode_pins` from the previous clock edge. After release, `mode_o` keeps the value sampled on the last reset cycle, whatever the pins do afterwards.
- R2: A read at address 0x000B in a non-emulation mode returns {mode, 5'b00000}: mode in bits 7..5 and zero in bits 4..0. A read of any other address returns 0.
- R3: Mode encoding: 000 special single-chip, 001 emulation single-chip, 010 special test, 011 emulation expanded, 100 normal single-chip, 101 normal expanded. Codes 110 and 111 are treated as non-special, non-emulation modes. In mode 100, an unlocked, unsecured write with data bits 7..5 = 101 sets the mode to 101 on the next cycle.
- R4: In mode 001, the same unlocked, unsecured write of 101 in bits 7..5 sets the mode to 011.
- R5: A permitted step is accepted once. After it, no further write changes the mode until reset.
- R6: In any non-special mode, any other first write leaves the mode unchanged and blocks all later writes until reset. This covers any value other than a permitted step, and any write in 011, 101, 110 or 111.
- R7: While `secured` is high, a write in a non-special mode leaves the mode unchanged and blocks later writes.
- R8: In special modes (000, 010), each write loads data bits 7..5 into the mode on the next cycle, regardless of `secured`, and never sets the block.
- R9: In emulation modes (001, 011), a read at 0x000B returns `ext_rdata`.
- R10: `ext_wr_o` is high in exactly the cycles with a write at 0x000B while in an emulation mode. `ext_wdata_o` carries `bus_wdata`.
- R11: Writes to addresses other than 0x000B change nothing and do not set the block.
- R12: Reset clears the block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; pins are sampled while low |
| mode_pins | input | 3 | External mode straps |
| secured | input | 1 | Device-secured flag |
| bus_addr | input | ADDR_W | Register bus address |
| bus_wr | input | 1 | Write enable |
| bus_rd | input | 1 | Read enable |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| ext_rdata | input | 8 | Read data from the external bus |
| ext_wr_o | output | 1 | Write-forward strobe for emulation modes |
| ext_wdata_o | output | 8 | Forwarded write data |
| mode_o | output | 3 | Current operating mode |

## Verification
Two things happen on the same edge: the first write both decides the mode step and sets the block. A second write must then see the block and nothing else. The bench provokes this for every strap combination, both secured states and all eight written codes. It follows each first write with a 101 write and a 100 write, so a step that was taken, missed or repeated shows up in `mode_o`. Expected modes come from a bench function built from the encoding and rules above.

// File: rtl/mode_guard_reg.sv
`timescale 1ns/1ps
module mode_guard_reg #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h000B,
  parameter logic [2:0] ENTRY_CODE = 3'b101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode_pins,
  input  logic              secured,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [7:0]        ext_rdata,
  output logic              ext_wr_o,
  output logic [7:0]        ext_wdata_o,
  output logic [2:0]        mode_o
);
  localparam logic [2:0] M_SPC_SC = 3'b000;
  localparam logic [2:0] M_EMU_SC = 3'b001;
  localparam logic [2:0] M_SPC_TS = 3'b010;
  localparam logic [2:0] M_EMU_EX = 3'b011;
  localparam logic [2:0] M_NRM_SC = 3'b100;
  localparam logic [2:0] M_NRM_EX = 3'b101;

  logic [2:0] mode_q;
  logic       lock_q;
  logic       hit, wr_hit, special, emul, step_ok;
  logic [2:0] wval;

  assign hit     = (bus_addr == REG_ADDR);
  assign wr_hit  = hit && bus_wr;
  assign wval    = bus_wdata[7:5];
  assign special = (mode_q == M_SPC_SC) || (mode_q == M_SPC_TS);
  assign emul    = (mode_q == M_EMU_SC) || (mode_q == M_EMU_EX);
  assign step_ok = !lock_q && !secured && (wval == ENTRY_CODE) &&
                   ((mode_q == M_NRM_SC) || (mode_q == M_EMU_SC));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= mode_pins;
      lock_q <= 1'b0;
    end else if (wr_hit) begin
      if (special) begin
        mode_q <= wval;
      end else begin
        lock_q <= 1'b1;
        if (step_ok)
          mode_q <= (mode_q == M_EMU_SC) ? M_EMU_EX : M_NRM_EX;
      end
    end
  end

  assign mode_o      = mode_q;
  assign ext_wr_o    = wr_hit && emul;
  assign ext_wdata_o = bus_wdata;
  assign bus_rdata   = !(hit && bus_rd) ? 8'h00 :
                       emul ? ext_rdata : {mode_q, 5'b00000};

  p_step_normal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && mode_q == M_NRM_SC && !lock_q && !secured && wval == ENTRY_CODE)
      |=> mode_o == M_NRM_EX);

  p_step_emul_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && mode_q == M_EMU_SC && !lock_q && !secured && wval == ENTRY_CODE)
      |=> mode_o == M_EMU_EX);

  p_locked_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !special) |=> $stable(mode_o));

  p_secured_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !special && secured) |=> ($stable(mode_o) && lock_q));

  p_special_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && special) |=> (mode_o == $past(wval)));

  p_read_low_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && bus_rd && !emul) |-> (bus_rdata[4:0] == 5'b00000));

  p_no_fwd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !emul |-> !ext_wr_o);
endmodule

// File: tb/test_mode_guard_reg.sv
`timescale 1ns/1ps
module test_mode_guard_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mode_pins = 3'b000;
  logic        secured = 1'b0;
  logic [15:0] bus_addr = 16'h0000;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_wdata = 8'h00, ext_rdata = 8'h00;
  logic [7:0]  bus_rdata, ext_wdata_o;
  logic        ext_wr_o;
  logic [2:0]  mode_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mode_guard_reg i_mode_guard_reg (
    .clk(clk), .rst_n(rst_n), .mode_pins(mode_pins), .secured(secured),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ext_rdata(ext_rdata), .ext_wr_o(ext_wr_o),
    .ext_wdata_o(ext_wdata_o), .mode_o(mode_o));

  function automatic bit is_spc(input logic [2:0] m);
    return (m == 3'd0) || (m == 3'd2);
  endfunction
  function automatic bit is_emu(input logic [2:0] m);
    return (m == 3'd1) || (m == 3'd3);
  endfunction
  function automatic logic [3:0] nxt(input logic [2:0] m, input logic lk,
                                     input logic sec, input logic [2:0] w);
    if (is_spc(m)) return {lk, w};
    if (lk) return {1'b1, m};
    if (!sec && w == 3'd5 && m == 3'd4) return {1'b1, 3'd5};
    if (!sec && w == 3'd5 && m == 3'd1) return {1'b1, 3'd3};
    return {1'b1, m};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [2:0] p, input logic sec);
    @(negedge clk);
    rst_n = 1'b0; mode_pins = p; secured = sec;
    @(negedge clk); @(negedge clk);
    chk("R1 during reset", {5'b0, mode_o}, {5'b0, p});
    rst_n = 1'b1;
    mode_pins = ~p;
    @(negedge clk);
    chk("R1 latched", {5'b0, mode_o}, {5'b0, p});
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input bit exp_fwd,
                    input string req);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    #1;
    chk({req, " R10 fwd"}, {7'b0, ext_wr_o}, {7'b0, exp_fwd});
    if (exp_fwd) chk("R10 data", ext_wdata_o, d);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [15:0] a, input logic [7:0] exp, input string req);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    chk(req, bus_rdata, exp);
    bus_rd = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    logic [2:0] m;
    logic       lk;
    logic [3:0] r;
    for (int p = 0; p < 8; p++) begin
      for (int s = 0; s < 2; s++) begin
        for (int w = 0; w < 8; w++) begin
          do_reset(p[2:0], s[0]);
          m = p[2:0]; lk = 1'b0;
          ext_rdata = 8'(p * 37 + w * 11 + s);
          rd_chk(16'h000B, is_emu(m) ? ext_rdata : {m, 5'b0}, "R2 R9 read");
          r = nxt(m, lk, s[0], w[2:0]);
          wr(16'h000B, {w[2:0], 5'b10101}, is_emu(m), "R3 R4 R6 R7 R8 first");
          {lk, m} = r;
          chk("R3 R4 R6 R7 R8 first write", {5'b0, mode_o}, {5'b0, m});
          r = nxt(m, lk, s[0], 3'd5);
          wr(16'h000B, 8'hA0, is_emu(m), "R5 R6 second");
          {lk, m} = r;
          chk("R5 R6 second write", {5'b0, mode_o}, {5'b0, m});
          r = nxt(m, lk, s[0], 3'd4);
          wr(16'h000B, 8'h80, is_emu(m), "R5 third");
          {lk, m} = r;
          chk("R5 third write", {5'b0, mode_o}, {5'b0, m});
          rd_chk(16'h000C, 8'h00, "R2 other address read");
        end
      end
    end
    // R11: stray-address writes neither change nor lock; R12: reset clears block
    do_reset(3'd4, 1'b0);
    wr(16'h000C, 8'hA0, 1'b0, "R11");
    wr(16'h010B, 8'h00, 1'b0, "R11");
    chk("R11 no change", {5'b0, mode_o}, 8'd4);
    wr(16'h000B, 8'hA0, 1'b0, "R11");
    chk("R11 no lock", {5'b0, mode_o}, 8'd5);
    do_reset(3'd4, 1'b0);
    wr(16'h000B, 8'h20, 1'b0, "R12");
    do_reset(3'd4, 1'b0);
    wr(16'h000B, 8'hA0, 1'b0, "R12");
    chk("R12 block cleared", {5'b0, mode_o}, 8'd5);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule